// File: doc/BRIEF.md
# Bit String Search Engine

This block is a multicycle engine that walks a bit string held in word-addressed memory and stops at the first bit equal to a chosen value. A caller supplies a start address, a bit offset inside the addressed 32-bit word, a length in bits, the value to look for (0 or 1), a direction (toward higher or toward lower bit positions), and a starting value for a skipped-bit counter. The engine fetches words through a 32-bit read port with a stall handshake and examines one bit per clock. It reports the updated address, offset and remaining length, the accumulated count of non-matching bits, a zero flag that stays high only when no match was seen, and an estimated cycle cost.

The skipped counter adds to whatever value is loaded at start, so a search that was split into several calls can keep one running total. The zero flag is the result that the caller tests. The matching bit is itself consumed: the offset and length step past it before the engine stops, so a later call resumes just after the hit.

Top module: `bss_search_engine`

## Requirements
- R1: On a `start` pulse while idle, the engine loads the address with its two low bits cleared, the offset as `start_bit` modulo 32, the remaining length from `start_len`, the skipped counter from `start_skip`, and sets `zero_flag` to 1. It also latches the search value (`find_one`) and the direction (`go_down`, where 1 means toward lower bit positions).
- R2: When `start_len` is 0, `done` pulses in the cycle after `start` and no read is issued. `zero_flag` stays 1 and the outputs keep the values loaded under R1.
- R3: Each examined bit is bit `cur_bit` of the fetched word, where bit 0 is the least significant. A bit that differs from the search value adds 1 to `skip_cnt`. A bit that equals it clears `zero_flag` and leaves `skip_cnt` unchanged.
- R4: After every examined bit, including a matching one, the offset moves by +1 (upward) or −1 (downward) modulo 32, and the remaining length drops by 1.
- R5: When the offset wraps to 0 going upward or to 31 going downward, the address moves by +4 or −4. This also happens on the last examined bit. If the search goes on, a new word is fetched before the next bit is examined.
- R6: The search ends after a matching bit or when the length reaches 0. `done` is high for exactly one cycle, in the cycle after the final examined bit, and `busy` is low from that cycle on.
- R7: `cycles` is 50 from the start cycle onward and gains 5 for each accepted word read.
- R8: The engine examines exactly one bit per clock while scanning, and examines no bit in a cycle that requests a read.
- R9: A read is accepted in a cycle with `mem_req` high and `mem_stall` low, and `mem_rdata` is taken in that same cycle. While `mem_stall` holds a request, the address, offset, length, counters and flag all stay unchanged.
- R10: After reset, `busy`, `done` and `mem_req` are 0 and `cycles`, `skip_cnt` and `cur_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (used only while idle) |
| find_one | input | 1 | Value searched for |
| go_down | input | 1 | 1: toward lower bit positions and addresses |
| start_addr | input | ADDR_W | Byte address of the first word |
| start_bit | input | OFS_IN_W | Starting bit offset, taken modulo 32 |
| start_len | input | LEN_W | Number of bits to examine |
| start_skip | input | CNT_W | Initial skipped-bit count |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid when the request is accepted |
| mem_stall | input | 1 | Memory not ready; request is held |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_addr | output | ADDR_W | Current word address |
| cur_bit | output | 5 | Current bit offset |
| cur_len | output | LEN_W | Bits remaining |
| skip_cnt | output | CNT_W | Accumulated non-matching bit count |
| zero_flag | output | 1 | 1 while no matching bit has been seen |
| cycles | output | CYC_W | Estimated cycle cost of the search |

## Verification
The key case is a single examined bit that does two things at once: it matches, or it is the last bit allowed by the length, and it also sits at the word edge, so the address step and the stop fall on the same clock. The sweep starts at offsets 30, 31, 0 and 1 in both directions, with lengths that end exactly on a word edge and with word patterns that put matches at bit 0 and bit 31. Each final address is compared with a bench model that moves the address whenever the offset wraps, whether or not the search stops there. Random read stalls are mixed in, so that fetch acceptance and held state are also judged against the model's count of reads and examined bits.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SCAN  = 2'd2
    } bss_state_e;

endpackage

// File: rtl/bss_bit_sel.sv
// Picks one bit of the held word and compares it with the search value.
module bss_bit_sel #(
    parameter int WORD_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              want,
    output logic              hit
);
    always_comb begin
        hit = (word[ofs] == want);
    end
endmodule

// File: rtl/bss_ofs_step.sv
// Moves the bit offset one place and flags a crossing into the next word.
module bss_ofs_step #(
    parameter int OFS_W = 5
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             down,
    output logic [OFS_W-1:0] ofs_next,
    output logic             wrap
);
    always_comb begin
        if (down) begin
            ofs_next = ofs - OFS_W'(1);
            wrap     = (ofs_next == {OFS_W{1'b1}});
        end else begin
            ofs_next = ofs + OFS_W'(1);
            wrap     = (ofs_next == '0);
        end
    end
endmodule

// File: rtl/bss_addr_step.sv
// Next word address in the search direction.
module bss_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              down,
    output logic [ADDR_W-1:0] addr_next
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);

    always_comb begin
        addr_next = down ? (addr - STRIDE) : (addr + STRIDE);
    end
endmodule

// File: rtl/bss_search_engine.sv
module bss_search_engine #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 32,
    parameter int CNT_W     = 32,
    parameter int CYC_W     = 32,
    parameter int OFS_IN_W  = 8,
    parameter int SETUP_CYC = 50,
    parameter int WORD_CYC  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         find_one,
    input  logic                         go_down,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic [OFS_IN_W-1:0]          start_bit,
    input  logic [LEN_W-1:0]             start_len,
    input  logic [CNT_W-1:0]             start_skip,
    output logic                         mem_req,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic [bss_pkg::WORD_W-1:0]   mem_rdata,
    input  logic                         mem_stall,
    output logic                         busy,
    output logic                         done,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [bss_pkg::OFS_W-1:0]    cur_bit,
    output logic [LEN_W-1:0]             cur_len,
    output logic [CNT_W-1:0]             skip_cnt,
    output logic                         zero_flag,
    output logic [CYC_W-1:0]             cycles
);
    import bss_pkg::*;

    localparam logic [ADDR_W-1:0]   ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [OFS_IN_W-1:0] OFS_MASK   = OFS_IN_W'(WORD_W - 1);
    localparam logic [CYC_W-1:0]    SETUP_COST = CYC_W'(SETUP_CYC);
    localparam logic [CYC_W-1:0]    WORD_COST  = CYC_W'(WORD_CYC);
    localparam logic [LEN_W-1:0]    LEN_ONE    = LEN_W'(1);

    typedef struct packed {
        bss_state_e          state;
        logic                down;
        logic                want;
        logic [ADDR_W-1:0]   addr;
        logic [OFS_W-1:0]    ofs;
        logic [LEN_W-1:0]    len;
        logic [CNT_W-1:0]    skip;
        logic                zf;
        logic [WORD_W-1:0]   word;
        logic [CYC_W-1:0]    cyc;
        logic                done;
    } eng_t;

    localparam eng_t ENG_RESET = '{
        state: ST_IDLE,
        down:  1'b0,
        want:  1'b0,
        addr:  '0,
        ofs:   '0,
        len:   '0,
        skip:  '0,
        zf:    1'b0,
        word:  '0,
        cyc:   '0,
        done:  1'b0
    };

    eng_t eng_d, eng_q;

    logic              bit_hit;
    logic [OFS_W-1:0]  ofs_stepped;
    logic              ofs_wrap;
    logic [ADDR_W-1:0] addr_stepped;

    bss_bit_sel #(
        .WORD_W (WORD_W),
        .OFS_W  (OFS_W)
    ) u_bit_sel (
        .word (eng_q.word),
        .ofs  (eng_q.ofs),
        .want (eng_q.want),
        .hit  (bit_hit)
    );

    bss_ofs_step #(
        .OFS_W (OFS_W)
    ) u_ofs_step (
        .ofs      (eng_q.ofs),
        .down     (eng_q.down),
        .ofs_next (ofs_stepped),
        .wrap     (ofs_wrap)
    );

    bss_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_addr_step (
        .addr      (eng_q.addr),
        .down      (eng_q.down),
        .addr_next (addr_stepped)
    );

    // Next-state computation
    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;

        unique case (eng_q.state)
            ST_IDLE: begin
                if (start) begin
                    eng_d.down = go_down;
                    eng_d.want = find_one;
                    eng_d.addr = start_addr & ALIGN_MASK;
                    eng_d.ofs  = OFS_W'(start_bit & OFS_MASK);
                    eng_d.len  = start_len;
                    eng_d.skip = start_skip;
                    eng_d.zf   = 1'b1;
                    eng_d.cyc  = SETUP_COST;
                    if (start_len == '0) begin
                        eng_d.done  = 1'b1;
                        eng_d.state = ST_IDLE;
                    end else begin
                        eng_d.state = ST_FETCH;
                    end
                end
            end

            ST_FETCH: begin
                if (!mem_stall) begin
                    eng_d.word  = mem_rdata;
                    eng_d.cyc   = eng_q.cyc + WORD_COST;
                    eng_d.state = ST_SCAN;
                end
            end

            ST_SCAN: begin
                if (bit_hit) begin
                    eng_d.zf = 1'b0;
                end else begin
                    eng_d.skip = eng_q.skip + CNT_W'(1);
                end
                eng_d.ofs = ofs_stepped;
                eng_d.len = eng_q.len - LEN_ONE;
                if (ofs_wrap) begin
                    eng_d.addr = addr_stepped;
                end
                if (bit_hit || (eng_q.len == LEN_ONE)) begin
                    eng_d.done  = 1'b1;
                    eng_d.state = ST_IDLE;
                end else if (ofs_wrap) begin
                    eng_d.state = ST_FETCH;
                end else begin
                    eng_d.state = ST_SCAN;
                end
            end

            default: begin
                eng_d = ENG_RESET;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= ENG_RESET;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        mem_req   = (eng_q.state == ST_FETCH);
        mem_addr  = eng_q.addr;
        busy      = (eng_q.state != ST_IDLE);
        done      = eng_q.done;
        cur_addr  = eng_q.addr;
        cur_bit   = eng_q.ofs;
        cur_len   = eng_q.len;
        skip_cnt  = eng_q.skip;
        zero_flag = eng_q.zf;
        cycles    = eng_q.cyc;
    end

endmodule

// File: rtl/bss_search_chk.sv
module bss_search_chk #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 32,
    parameter int CNT_W    = 32,
    parameter int CYC_W    = 32,
    parameter int WORD_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_stall,
    input logic              busy,
    input logic              done,
    input logic [LEN_W-1:0]  cur_len,
    input logic [CNT_W-1:0]  skip_cnt,
    input logic              zero_flag,
    input logic [CYC_W-1:0]  cycles
);
    logic scanning;
    always_comb scanning = busy && !mem_req;

    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |=> ((skip_cnt == $past(skip_cnt) + CNT_W'(1)) && zero_flag) ||
                     ((skip_cnt == $past(skip_cnt)) && !zero_flag));

    assert_len_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |=> (cur_len == $past(cur_len) - LEN_W'(1)));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hit_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |=> (zero_flag || !busy));

    assert_read_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_stall) |=> (cycles == $past(cycles) + CYC_W'(WORD_CYC)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_stall) |=> (mem_req && $stable(mem_addr) && $stable(cur_len) &&
                                    $stable(skip_cnt) && $stable(cycles)));
endmodule

bind bss_search_engine bss_search_chk #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .CYC_W    (CYC_W),
    .WORD_CYC (WORD_CYC)
) u_bss_search_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_stall (mem_stall),
    .busy      (busy),
    .done      (done),
    .cur_len   (cur_len),
    .skip_cnt  (skip_cnt),
    .zero_flag (zero_flag),
    .cycles    (cycles)
);

// File: tb/tb_bss_search_engine.sv
module tb_bss_search_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        find_one = 1'b0;
    logic        go_down = 1'b0;
    logic [31:0] start_addr = '0;
    logic [7:0]  start_bit = '0;
    logic [31:0] start_len = '0;
    logic [31:0] start_skip = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        mem_stall = 1'b0;
    logic        busy, done, zero_flag;
    logic [31:0] cur_addr, cur_len, skip_cnt, cycles;
    logic [4:0]  cur_bit;

    logic [31:0] mem [8];
    logic [15:0] lfsr = 16'hACE1;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[4:2]];

    bss_search_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .find_one(find_one), .go_down(go_down),
        .start_addr(start_addr), .start_bit(start_bit), .start_len(start_len),
        .start_skip(start_skip), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_stall(mem_stall), .busy(busy), .done(done),
        .cur_addr(cur_addr), .cur_bit(cur_bit), .cur_len(cur_len), .skip_cnt(skip_cnt),
        .zero_flag(zero_flag), .cycles(cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    function automatic logic [31:0] pat_word(input int p, input int i);
        case (p)
            0: return 32'h0;
            1: return 32'h1 << ((i * 5) % 32);
            2: return ~(32'h8000_0000 >> ((i * 7) % 32));
            default: return (32'h9E37_79B9 * (i + 1)) ^ 32'h0F0F_3C3C;
        endcase
    endfunction

    // Bench model built from the requirements
    task automatic model(input logic want, input logic dn, input logic [31:0] a0,
                         input logic [7:0] b0, input logic [31:0] l0, input logic [31:0] s0,
                         output logic [31:0] a, output logic [4:0] b, output logic [31:0] l,
                         output logic [31:0] s, output logic z, output int reads,
                         output int scans);
        logic [31:0] w;
        a = a0 & 32'hFFFF_FFFC;
        b = 5'(b0 % 32);
        l = l0;
        s = s0;
        z = 1'b1;
        reads = 0;
        scans = 0;
        while (z && l != 0) begin
            logic wrapped;
            w = mem[a[4:2]];
            reads++;
            wrapped = 1'b0;
            while (z && l != 0 && !wrapped) begin
                if (w[b] == want) z = 1'b0;
                else s = s + 1;
                b = dn ? b - 5'd1 : b + 5'd1;
                l = l - 1;
                scans++;
                wrapped = dn ? (b == 5'd31) : (b == 5'd0);
                if (wrapped) a = dn ? a - 32'd4 : a + 32'd4;
            end
        end
    endtask

    task automatic run_case(input logic want, input logic dn, input logic [31:0] a0,
                            input logic [7:0] b0, input logic [31:0] l0,
                            input logic [31:0] s0);
        logic [31:0] ea, el, es;
        logic [4:0]  eb;
        logic        ez;
        int          er, esc;
        int          reads, scans, waited;
        bit          hold_ok, prev_stall;
        logic [31:0] prev_addr, prev_len;
        model(want, dn, a0, b0, l0, s0, ea, eb, el, es, ez, er, esc);
        @(negedge clk);
        find_one = want; go_down = dn; start_addr = a0; start_bit = b0;
        start_len = l0; start_skip = s0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        reads = 0; scans = 0; waited = 0; hold_ok = 1'b1; prev_stall = 1'b0;
        prev_addr = '0; prev_len = '0;
        while (!done && waited < 400) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_stall = lfsr[0] & lfsr[3];
            #1;
            if (prev_stall && (!mem_req || mem_addr != prev_addr || cur_len != prev_len))
                hold_ok = 1'b0;
            prev_stall = mem_req && mem_stall;
            prev_addr = mem_addr;
            prev_len = cur_len;
            if (mem_req && !mem_stall) reads++;
            if (busy && !mem_req) scans++;
            waited++;
            @(negedge clk);
        end
        chk(done == 1'b1, "R6", "done seen", 64'(done), 64'd1);
        chk(busy == 1'b0, "R6", "busy at done", 64'(busy), 64'd0);
        chk(cur_addr == ea, "R5", "address", 64'(cur_addr), 64'(ea));
        chk(cur_bit == eb, "R4", "offset", 64'(cur_bit), 64'(eb));
        chk(cur_len == el, "R4", "length", 64'(cur_len), 64'(el));
        chk(skip_cnt == es, "R3", "skipped", 64'(skip_cnt), 64'(es));
        chk(zero_flag == ez, "R3", "zero flag", 64'(zero_flag), 64'(ez));
        chk(reads == er, "R5", "read count", 64'(reads), 64'(er));
        chk(scans == esc, "R8", "bits per clock", 64'(scans), 64'(esc));
        chk(cycles == 32'(50 + 5 * er), "R7", "cycle cost", 64'(cycles), 64'(50 + 5 * er));
        chk(hold_ok, "R9", "stall hold", 64'(hold_ok), 64'd1);
        if (l0 == 0) begin
            chk(waited == 0 && reads == 0, "R2", "zero length immediate", 64'(waited), 64'd0);
            chk(zero_flag == 1'b1 && cur_bit == 5'(b0 % 32) && skip_cnt == s0, "R1",
                "start load", 64'({zero_flag, cur_bit}), 64'({1'b1, 5'(b0 % 32)}));
        end
        mem_stall = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        int bits [6];
        int lens [6];
        int run;
        bits = '{0, 1, 30, 31, 15, 37};
        lens = '{0, 1, 2, 5, 33, 70};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10", "reset controls",
            64'({busy, done, mem_req}), 64'd0);
        chk(cycles == 0 && skip_cnt == 0 && cur_len == 0, "R10", "reset counters",
            64'(cycles | skip_cnt | cur_len), 64'd0);
        run = 0;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) mem[i] = pat_word(p, i);
            for (int d = 0; d < 2; d++) begin
                for (int v = 0; v < 2; v++) begin
                    for (int bi = 0; bi < 6; bi++) begin
                        for (int li = 0; li < 6; li++) begin
                            run_case(v[0], d[0], 32'h100 + 32'((run * 5) % 32),
                                     8'(bits[bi]), 32'(lens[li]), 32'(run * 3));
                            run++;
                        end
                    end
                end
            end
        end
        summary();
        $finish;
    end

endmodule